// File: doc/BRIEF.md
# Receive Descriptor Ownership Tracker

This block follows who owns the receive descriptors of a ring held in host memory: either the host, or the receiver. It keeps one cached ownership bit for the descriptor now in use (the current slot) and one for the descriptor after it (the next slot). When the shared poll scheduler pulses a poll request, the block reads only the descriptors whose ownership it has not yet confirmed. Once it holds both, scheduled polls cost no memory traffic.

When the address filter accepts an incoming frame and the current buffer is not known to be owned, the block makes one immediate extra read of the current descriptor. If that read still shows the host as owner, there is no place to store the frame. The block raises a sticky missed-frame flag, gates it into an interrupt through an enable and a mask, and makes no further current-descriptor read until the frame ends. When the current descriptor is owned, the block reads the next descriptor once and then enables data transfer into the current buffer. It does this whatever that read returns. A separate advance strobe moves the ring forward and shifts the cached next-ownership bit into the current slot.

Top module: `rxo_tracker`

## Requirements
- R1: After synchronous reset the following outputs are 0: own_cur, own_nxt, cur_idx, xfer_en, rd_req, miss_flag and miss_irq.
- R2: cur_advance is acted on only when no descriptor read is pending. Each accepted advance moves cur_idx to the next index, and after ring_len-1 the next index is 0. A read of the next descriptor uses index cur_idx+1, which wraps to 0 at ring_len.
- R3: A poll_req pulse makes the block read the current descriptor if own_cur is 0. If own_cur is 1 (already cached, or just read as 1), ring_len>1 and own_nxt is 0, the block reads the next descriptor. A read holds rd_req high with a stable rd_idx until rd_ack. rd_own=1 with rd_ack means the receiver owns that descriptor.
- R4: With ring_len equal to 1, only the current descriptor (index 0) is ever read, and own_nxt stays 0.
- R5: While own_cur and own_nxt are both 1 (or own_cur is 1 with ring_len 1), poll_req issues no read.
- R6: A frame_acc pulse while own_cur is 0 issues exactly one immediate read of the current descriptor.
- R7: If that extra read returns rd_own=0, miss_flag is set and xfer_en stays 0. Every poll_req is then ignored until frame_end, and polling resumes after it.
- R8: miss_irq is 1 only when miss_flag, int_en and not miss_mask are all true. miss_clr clears miss_flag. A set in the same cycle wins over a clear.
- R9: When the current descriptor is owned at frame acceptance (cached, or found by the extra read), the block reads the next descriptor once if ring_len>1 and own_nxt is 0. It then raises xfer_en whatever that read returned. xfer_en holds until frame_end, and poll_req issues no read meanwhile.
- R10: An accepted advance copies own_nxt into own_cur and clears own_nxt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_len | input | IDX_W+1 | Ring length, 1 to MAX_DESC |
| poll_req | input | 1 | Scheduled poll strobe |
| frame_acc | input | 1 | Frame accepted by the address filter |
| frame_end | input | 1 | Current frame finished |
| cur_advance | input | 1 | Move to the next descriptor |
| rd_req | output | 1 | Descriptor read request |
| rd_idx | output | IDX_W | Index of the descriptor being read |
| rd_ack | input | 1 | Read completed this cycle |
| rd_own | input | 1 | Ownership value returned with rd_ack |
| xfer_en | output | 1 | Data transfer into the current buffer allowed |
| int_en | input | 1 | Global interrupt enable |
| miss_mask | input | 1 | Missed-frame interrupt mask |
| miss_clr | input | 1 | Clear the missed-frame flag |
| miss_flag | output | 1 | Sticky missed-frame status |
| miss_irq | output | 1 | Missed-frame interrupt |
| own_cur | output | 1 | Cached ownership of the current descriptor |
| own_nxt | output | 1 | Cached ownership of the next descriptor |
| cur_idx | output | IDX_W | Current descriptor index |

## Verification
Several checks run on every cycle. A scheduled poll while both descriptors are cached as owned must leave the read port quiet. An advance must land on the computed next index and move the next-ownership bit into the current slot. Transfer must never start without current ownership. A ring of one must never address anything but the current slot, and the interrupt must never rise without the flag. Other behaviour only shows across whole scenarios, which the bench sweeps over ring lengths and descriptor ownership patterns. This includes the exact number and order of reads for each mix of cached and in-memory ownership, the single extra read on frame acceptance, the poll silence that lasts until a missed frame ends, and transfer starting even when the next descriptor is not owned.

// File: rtl/rxo_pkg.sv
package rxo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL_CUR,
        ST_POLL_NXT,
        ST_LAST_CUR,
        ST_RX_NXT,
        ST_XFER,
        ST_MISS
    } trk_state_e;

    typedef enum logic {
        SEL_CUR = 1'b0,
        SEL_NXT = 1'b1
    } rd_sel_e;

    // ownership write produced when a descriptor read completes
    typedef struct packed {
        logic wr_cur;
        logic wr_nxt;
        logic own;
    } own_upd_t;

    function automatic logic is_read_state(trk_state_e s);
        return (s == ST_POLL_CUR) || (s == ST_POLL_NXT) ||
               (s == ST_LAST_CUR) || (s == ST_RX_NXT);
    endfunction

    function automatic rd_sel_e sel_of(trk_state_e s);
        return ((s == ST_POLL_NXT) || (s == ST_RX_NXT)) ? SEL_NXT : SEL_CUR;
    endfunction

endpackage

// File: rtl/rxo_ring_ptr.sv
module rxo_ring_ptr #(
    parameter int MAX_DESC = 8,
    parameter int IDX_W    = $clog2(MAX_DESC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W:0]   ring_len,
    input  logic             adv,
    output logic [IDX_W-1:0] cur_idx,
    output logic [IDX_W-1:0] nxt_idx,
    output logic             single
);
    localparam logic [IDX_W:0] ONE_W = (IDX_W+1)'(1);

    logic [IDX_W-1:0] cur_q;
    logic [IDX_W:0]   inc;

    always_comb begin
        inc     = {1'b0, cur_q} + ONE_W;
        nxt_idx = (inc >= ring_len) ? '0 : inc[IDX_W-1:0];
        single  = (ring_len <= ONE_W);
    end

    always_ff @(posedge clk) begin
        if (rst)      cur_q <= '0;
        else if (adv) cur_q <= nxt_idx;
    end

    assign cur_idx = cur_q;

    // R2: an advance lands on the index that was offered as next
    p_adv_lands_r2: assert property (@(posedge clk) disable iff (rst)
        adv |=> cur_idx == $past(nxt_idx));

endmodule

// File: rtl/rxo_own_cache.sv
module rxo_own_cache
    import rxo_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  own_upd_t upd,
    input  logic     adv,
    output logic     own_cur,
    output logic     own_nxt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            own_cur <= 1'b0;
            own_nxt <= 1'b0;
        end else if (adv) begin
            own_cur <= own_nxt;
            own_nxt <= 1'b0;
        end else begin
            if (upd.wr_cur) own_cur <= upd.own;
            if (upd.wr_nxt) own_nxt <= upd.own;
        end
    end

    // R10: advancing promotes the next slot and empties it
    p_promote_r10: assert property (@(posedge clk) disable iff (rst)
        adv |=> (own_cur == $past(own_nxt)) && !own_nxt);

endmodule

// File: rtl/rxo_miss_irq.sv
module rxo_miss_irq (
    input  logic clk,
    input  logic rst,
    input  logic miss_set,
    input  logic miss_clr,
    input  logic int_en,
    input  logic miss_mask,
    output logic miss_flag,
    output logic miss_irq
);
    always_ff @(posedge clk) begin
        if (rst)           miss_flag <= 1'b0;
        else if (miss_set) miss_flag <= 1'b1;
        else if (miss_clr) miss_flag <= 1'b0;
    end

    assign miss_irq = miss_flag & int_en & ~miss_mask;

    // R8: the flag is sticky until cleared
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (miss_flag && !miss_clr) |=> miss_flag);

    // R8: the flag only rises after a set request
    p_flag_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(miss_flag) |-> $past(miss_set));

endmodule

// File: rtl/rxo_ctrl.sv
module rxo_ctrl
    import rxo_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     poll_req,
    input  logic     frame_acc,
    input  logic     frame_end,
    input  logic     rd_ack,
    input  logic     rd_own,
    input  logic     own_cur,
    input  logic     own_nxt,
    input  logic     single,
    output logic     rd_req,
    output rd_sel_e  rd_sel,
    output own_upd_t upd,
    output logic     miss_set,
    output logic     xfer_en,
    output logic     adv_ok
);
    trk_state_e st_q, st_d;
    logic       acc_pend_q, acc_pend_d;
    logic       acc;
    logic       done;
    logic       need_nxt;

    always_comb begin
        rd_req   = is_read_state(st_q);
        rd_sel   = sel_of(st_q);
        done     = rd_req && rd_ack;
        acc      = frame_acc || acc_pend_q;
        need_nxt = !single && !own_nxt;
        xfer_en  = (st_q == ST_XFER);
        adv_ok   = !rd_req;

        upd.wr_cur = done && (rd_sel == SEL_CUR);
        upd.wr_nxt = done && (rd_sel == SEL_NXT);
        upd.own    = rd_own;

        st_d       = st_q;
        acc_pend_d = acc_pend_q;
        miss_set   = 1'b0;

        unique case (st_q)
            ST_IDLE: begin
                acc_pend_d = 1'b0;
                if (acc) begin
                    if (!own_cur)      st_d = ST_LAST_CUR;
                    else if (need_nxt) st_d = ST_RX_NXT;
                    else               st_d = ST_XFER;
                end else if (poll_req) begin
                    if (!own_cur)      st_d = ST_POLL_CUR;
                    else if (need_nxt) st_d = ST_POLL_NXT;
                end
            end
            ST_POLL_CUR: begin
                if (frame_acc) acc_pend_d = 1'b1;
                if (rd_ack) st_d = (rd_own && need_nxt) ? ST_POLL_NXT : ST_IDLE;
            end
            ST_POLL_NXT: begin
                if (frame_acc) acc_pend_d = 1'b1;
                if (rd_ack) st_d = ST_IDLE;
            end
            ST_LAST_CUR: begin
                if (rd_ack) begin
                    if (!rd_own) begin
                        miss_set = 1'b1;
                        st_d     = ST_MISS;
                    end else if (need_nxt) begin
                        st_d = ST_RX_NXT;
                    end else begin
                        st_d = ST_XFER;
                    end
                end
            end
            ST_RX_NXT: begin
                if (rd_ack) st_d = ST_XFER;
            end
            ST_XFER, ST_MISS: begin
                if (frame_end) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            acc_pend_q <= 1'b0;
        end else begin
            st_q       <= st_d;
            acc_pend_q <= acc_pend_d;
        end
    end

    // R5: with both slots owned a lone poll produces no read
    p_poll_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && poll_req && !frame_acc && !acc_pend_q &&
         own_cur && (own_nxt || single)) |=> !rd_req);

    // R7: after a failed extra read the block sits out the frame
    p_miss_wait_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LAST_CUR && rd_ack && !rd_own) |=> (!rd_req && !xfer_en));

endmodule

// File: rtl/rxo_tracker.sv
module rxo_tracker
    import rxo_pkg::*;
#(
    parameter int MAX_DESC = 8,
    parameter int IDX_W    = $clog2(MAX_DESC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W:0]   ring_len,
    input  logic             poll_req,
    input  logic             frame_acc,
    input  logic             frame_end,
    input  logic             cur_advance,
    output logic             rd_req,
    output logic [IDX_W-1:0] rd_idx,
    input  logic             rd_ack,
    input  logic             rd_own,
    output logic             xfer_en,
    input  logic             int_en,
    input  logic             miss_mask,
    input  logic             miss_clr,
    output logic             miss_flag,
    output logic             miss_irq,
    output logic             own_cur,
    output logic             own_nxt,
    output logic [IDX_W-1:0] cur_idx
);
    logic [IDX_W-1:0] nxt_idx;
    logic             single;
    logic             adv_ok;
    logic             adv;
    logic             miss_set;
    rd_sel_e          rd_sel;
    own_upd_t         upd;

    assign adv    = cur_advance && adv_ok;
    assign rd_idx = (rd_sel == SEL_NXT) ? nxt_idx : cur_idx;

    rxo_ring_ptr #(.MAX_DESC(MAX_DESC), .IDX_W(IDX_W)) u_ptr (
        .clk(clk), .rst(rst), .ring_len(ring_len), .adv(adv),
        .cur_idx(cur_idx), .nxt_idx(nxt_idx), .single(single)
    );

    rxo_own_cache u_own (
        .clk(clk), .rst(rst), .upd(upd), .adv(adv),
        .own_cur(own_cur), .own_nxt(own_nxt)
    );

    rxo_ctrl u_ctrl (
        .clk(clk), .rst(rst), .poll_req(poll_req), .frame_acc(frame_acc),
        .frame_end(frame_end), .rd_ack(rd_ack), .rd_own(rd_own),
        .own_cur(own_cur), .own_nxt(own_nxt), .single(single),
        .rd_req(rd_req), .rd_sel(rd_sel), .upd(upd), .miss_set(miss_set),
        .xfer_en(xfer_en), .adv_ok(adv_ok)
    );

    rxo_miss_irq u_miss (
        .clk(clk), .rst(rst), .miss_set(miss_set), .miss_clr(miss_clr),
        .int_en(int_en), .miss_mask(miss_mask),
        .miss_flag(miss_flag), .miss_irq(miss_irq)
    );

    // R9: transfer never opens without current ownership
    p_xfer_owned_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_en) |-> own_cur);

    // R4: a one-entry ring only ever reads the current slot
    p_single_cur_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_req && single) |-> (rd_idx == cur_idx && !own_nxt));

    // R8: interrupt implies a pending flag
    p_irq_flag_r8: assert property (@(posedge clk) disable iff (rst)
        miss_irq |-> miss_flag);

endmodule

// File: tb/rxo_tracker_tb.sv
`timescale 1ns/1ps
module rxo_tracker_tb;
    localparam int MAX_DESC = 8;
    localparam int IDX_W    = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             rst = 1'b1;
    logic [IDX_W:0]   ring_len = 4'd1;
    logic             poll_req = 0, frame_acc = 0, frame_end = 0, cur_advance = 0;
    logic             rd_req, rd_ack = 0, rd_own = 0;
    logic [IDX_W-1:0] rd_idx, cur_idx;
    logic             xfer_en, int_en = 0, miss_mask = 0, miss_clr = 0;
    logic             miss_flag, miss_irq, own_cur, own_nxt;

    rxo_tracker #(.MAX_DESC(MAX_DESC), .IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst(rst), .ring_len(ring_len), .poll_req(poll_req),
        .frame_acc(frame_acc), .frame_end(frame_end), .cur_advance(cur_advance),
        .rd_req(rd_req), .rd_idx(rd_idx), .rd_ack(rd_ack), .rd_own(rd_own),
        .xfer_en(xfer_en), .int_en(int_en), .miss_mask(miss_mask),
        .miss_clr(miss_clr), .miss_flag(miss_flag), .miss_irq(miss_irq),
        .own_cur(own_cur), .own_nxt(own_nxt), .cur_idx(cur_idx)
    );

    // host memory model: ack one half cycle after a request is seen
    logic mem [MAX_DESC];
    int   rd_cnt = 0, rd_first = -1, rd_last = -1;
    always @(negedge clk) begin
        if (rd_req && !rd_ack) begin
            rd_ack <= 1'b1;
            rd_own <= mem[rd_idx];
            if (rd_cnt == 0) rd_first = int'(rd_idx);
            rd_last = int'(rd_idx);
            rd_cnt++;
        end else begin
            rd_ack <= 1'b0;
        end
    end

    int checks = 0, fails = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic settle(); repeat (10) @(negedge clk); endtask
    task automatic win(); rd_cnt = 0; rd_first = -1; rd_last = -1; endtask

    task automatic do_reset(int len);
        @(negedge clk); rst = 1'b1; ring_len = (IDX_W+1)'(len);
        for (int i = 0; i < MAX_DESC; i++) mem[i] = 1'b0;
        repeat (3) @(negedge clk); rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic p_poll();  @(negedge clk); poll_req = 1;  @(negedge clk); poll_req = 0;  settle(); endtask
    task automatic p_acc();   @(negedge clk); frame_acc = 1; @(negedge clk); frame_acc = 0; settle(); endtask
    task automatic p_end();   @(negedge clk); frame_end = 1; @(negedge clk); frame_end = 0; settle(); endtask
    task automatic p_adv();   @(negedge clk); cur_advance = 1; @(negedge clk); cur_advance = 0; @(negedge clk); endtask
    task automatic p_clr();   @(negedge clk); miss_clr = 1; @(negedge clk); miss_clr = 0; @(negedge clk); endtask

    function automatic int nidx(int c, int l);
        return (c + 1 >= l) ? 0 : c + 1;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset(4);
        chk("R1 own_cur", own_cur, 0);
        chk("R1 own_nxt", own_nxt, 0);
        chk("R1 cur_idx", cur_idx, 0);
        chk("R1 xfer_en", xfer_en, 0);
        chk("R1 rd_req", rd_req, 0);
        chk("R1 miss_flag", miss_flag, 0);
        chk("R1 miss_irq", miss_irq, 0);

        // R2 wrap sweep over every ring length
        for (int l = 1; l <= MAX_DESC; l++) begin
            do_reset(l);
            for (int k = 1; k <= 2 * l; k++) begin
                p_adv();
                chk($sformatf("R2 wrap len=%0d step=%0d", l, k), cur_idx, k % l);
            end
        end

        // R2 next-index wrap seen on the read port
        for (int l = 2; l <= 4; l++) begin
            do_reset(l);
            for (int k = 0; k < l - 1; k++) p_adv();
            for (int i = 0; i < MAX_DESC; i++) mem[i] = 1'b1;
            win(); p_poll();
            chk("R2 read count at last slot", rd_cnt, 2);
            chk("R2 first read index", rd_first, l - 1);
            chk("R2 wrapped next index", rd_last, nidx(l - 1, l));
        end

        // R3..R9 sweep over ring length and descriptor ownership
        for (int l = 1; l <= 3; l++) begin
            for (int mc = 0; mc < 2; mc++) begin
                for (int mn = 0; mn < 2; mn++) begin
                    int oc, on, er;
                    do_reset(l);
                    mem[0] = mc[0];
                    if (l > 1) mem[1] = mn[0];
                    oc = mc;
                    on = (l > 1 && mc == 1 && mn == 1) ? 1 : 0;

                    win(); p_poll();
                    er = (l == 1) ? 1 : 1 + mc;
                    chk($sformatf("R3/R4 first poll reads l=%0d mc=%0d mn=%0d", l, mc, mn), rd_cnt, er);
                    chk("R3 first poll index", rd_first, 0);
                    chk("R3 own_cur after poll", own_cur, oc);
                    chk("R3/R4 own_nxt after poll", own_nxt, on);

                    win(); p_poll();
                    er = (oc == 1 && (l == 1 || on == 1)) ? 0 : 1;
                    chk($sformatf("R5/R3 second poll reads l=%0d mc=%0d mn=%0d", l, mc, mn), rd_cnt, er);
                    chk("R3 own_cur stable", own_cur, oc);

                    win(); p_acc();
                    er = (oc == 0) ? 1 : ((l == 1 || on == 1) ? 0 : 1);
                    chk($sformatf("R6/R9 accept reads l=%0d mc=%0d mn=%0d", l, mc, mn), rd_cnt, er);
                    if (er == 1) chk("R6/R9 accept read index", rd_first, (oc == 0) ? 0 : 1);
                    chk("R9 xfer_en after accept", xfer_en, oc);
                    chk("R7 miss_flag after accept", miss_flag, 1 - oc);

                    win(); p_poll();
                    chk("R7/R9 poll ignored during frame", rd_cnt, 0);

                    p_end();
                    chk("R9 xfer_en after frame end", xfer_en, 0);
                    chk("R7 miss_flag sticky", miss_flag, 1 - oc);

                    if (oc == 0) begin
                        win(); p_poll();
                        chk("R7 polling resumes after frame", rd_cnt, 1);
                    end
                end
            end
        end

        // R6/R9 extra read succeeds, next not owned, transfer still opens
        do_reset(4);
        win(); p_poll();
        chk("R3 unowned poll reads current only", rd_cnt, 1);
        mem[0] = 1'b1; mem[1] = 1'b0;
        win(); p_acc();
        chk("R6/R9 reads after accept", rd_cnt, 2);
        chk("R6 extra read index", rd_first, 0);
        chk("R9 next read index", rd_last, 1);
        chk("R9 xfer despite next unowned", xfer_en, 1);
        chk("R7 no miss", miss_flag, 0);
        chk("R9 own_nxt", own_nxt, 0);
        p_end();

        // R10 promotion on advance
        do_reset(4);
        for (int i = 0; i < MAX_DESC; i++) mem[i] = 1'b1;
        p_poll();
        chk("R10 both owned before advance", own_cur + own_nxt, 2);
        p_adv();
        chk("R10 own_cur promoted", own_cur, 1);
        chk("R10 own_nxt cleared", own_nxt, 0);
        chk("R10 cur_idx moved", cur_idx, 1);
        p_adv();
        chk("R10 own_cur after second advance", own_cur, 0);

        // R8 interrupt gating and clear
        do_reset(2);
        p_acc();
        chk("R7 miss set", miss_flag, 1);
        for (int e = 0; e < 2; e++) begin
            for (int m = 0; m < 2; m++) begin
                @(negedge clk); int_en = e[0]; miss_mask = m[0];
                #1;
                chk($sformatf("R8 irq en=%0d mask=%0d", e, m), miss_irq, (e == 1 && m == 0) ? 1 : 0);
            end
        end
        int_en = 1; miss_mask = 0;
        p_end();
        p_clr();
        chk("R8 flag cleared", miss_flag, 0);
        chk("R8 irq cleared", miss_irq, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule